// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is the serial control port of a spread-spectrum clock generator. It watches a two-wire SMBus/I2C-style bus, answers only to its fixed 7-bit device address, and gives a host indexed block access to a small bank of configuration registers. The registers set the spread profile code, the output frequency choice, the spread on/off switch and the clock output enable. A read-only identity byte holds a revision and a vendor code.

The bus lines are sampled by the system clock through two-flop synchronizers. START and STOP are found as SDA edges while SCL is high. The block only ever pulls SDA low, so the bus stays open-drain. Every transfer first carries a register index. A write then carries a byte count followed by that many data bytes. A read uses a repeated START and a read address; the slave answers with a count byte and then data bytes until the host NACKs. After each data byte the index steps by one.

After reset the block is in hardware mode. In this mode the spread select and frequency select come from external pins, and they appear in register 0 as read-only bits. Setting the mode bit hands those fields to the register bank.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave ACKs an address byte whose upper 7 bits equal 1101010 (D4h write, D5h read). Any other address is NACKed, and the slave then never pulls SDA low until the next START.
- R2: A write is address+W, index N, count X, then data bytes. Each byte is ACKed, and data byte k goes to register N+k.
- R3: Data bytes beyond the count X are NACKed and are not written.
- R4: A read is address+W, index N, repeated START, address+R. The slave then returns a count byte equal to 7−N (00h when N ≥ 7), followed by registers N, N+1, … in turn. A host NACK ends the read.
- R5: Register 0 layout: bit7 S0, bit6 S1, bit5 S2, bit4 S3, bit3 frequency select, bit2 reads 0, bit1 spread enable (reset 1), bit0 mode (1 = software, reset 0 = hardware).
- R6: In hardware mode, register 0 bits 7:3 read as {0, pin S1, pin S2, pin S3, pin frequency}, and writes to them are dropped. spread_code is {pin S3, pin S2, pin S1, 0} and freq_sel follows the pin.
- R7: In software mode the stored bits 7:3 drive spread_code = {S3,S2,S1,S0} and freq_sel. Bits 7:3 are writable only when the mode bit is already 1 before the write.
- R8: Register 1 bit 2 is the output enable (reset 1). Its other bits read 0 and ignore writes.
- R9: Registers 2–5 and indices ≥ 7 read 00h. Register 6 reads {REV_ID, VENDOR_ID} (bits 7:4, 3:0). Writes to all of these have no effect.
- R10: A START at any point restarts address reception. A STOP returns the slave to idle.
- R11: sda_pull_low is low after reset. It asserts only in an ACK slot or a slave data bit slot, and only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_low | output | 1 | 1 = pull SDA low (open-drain driver enable) |
| pin_sel | input | 3 | Hardware spread select pins {S3,S2,S1} |
| pin_fsel | input | 1 | Hardware frequency select pin (1 = 100 MHz) |
| spread_code | output | 4 | Effective spread code {S3,S2,S1,S0} |
| freq_sel | output | 1 | Effective frequency select |
| spread_on | output | 1 | Spread modulation enable |
| out_en | output | 1 | Clock output enable |

## Verification
The in-line assertions are checked on every cycle. They cover the state after every START and STOP, the confinement of the SDA pull-down to ACK and data-out slots, that the pull-down only begins while SCL is low, and that the slave stays silent after a foreign address. They also check that writes to reserved indices, or to the software spread bits while in hardware mode, leave the stored state unchanged. Only the bench scenarios can show the byte-level results. These are the count byte for each start index, the wrap past the top register into zero reads, the NACK and drop of surplus bytes, the override of the pin values in each mode, and the readback of all 32 software settings of bits 7:3.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_IDX, ST_CNT, ST_WDATA,
    ST_ACK, ST_ACKHOLD, ST_TX, ST_TXEND, ST_HACK, ST_TXLOAD, ST_WAIT
  } smb_st_e;

  // registers 0..6 are decoded; anything above reads zero
  localparam logic [7:0] NUM_REGS = 8'd7;

  // count byte returned at the head of a read: registers left from idx
  function automatic logic [7:0] count_for(input logic [7:0] idx);
    return (idx < NUM_REGS) ? (NUM_REGS - idx) : 8'h00;
  endfunction

  // control byte image; sw_code is {S3,S2,S1,S0}, pins are {S3,S2,S1}
  function automatic logic [7:0] ctl_byte(input logic sw, input logic [3:0] sw_code,
                                          input logic sw_fsel, input logic en,
                                          input logic [2:0] pins, input logic pin_fsel);
    if (sw)
      return {sw_code[0], sw_code[1], sw_code[2], sw_code[3], sw_fsel, 1'b0, en, 1'b1};
    return {1'b0, pins[0], pins[1], pins[2], pin_fsel, 1'b0, en, 1'b0};
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_DEPTH-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_DEPTH-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_DEPTH-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_DEPTH-1];
      sda_q    <= sda_pipe[SYNC_DEPTH-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_DEPTH-1];
  assign sda_s     = sda_pipe[SYNC_DEPTH-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter logic [3:0] REV_ID    = 4'h2,
  parameter logic [3:0] VENDOR_ID = 4'h1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  input  logic [2:0] pin_sel,
  input  logic       pin_fsel,
  output logic [3:0] spread_code,
  output logic       freq_sel,
  output logic       spread_on,
  output logic       out_en
);
  logic       sw_mode, sw_fsel, spread_en, oen;
  logic [3:0] sw_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_mode   <= 1'b0;
      sw_code   <= 4'h0;
      sw_fsel   <= 1'b0;
      spread_en <= 1'b1;
      oen       <= 1'b1;
    end else if (wr_en) begin
      if (wr_idx == 8'd0) begin
        if (sw_mode) begin
          sw_code <= {wr_data[4], wr_data[5], wr_data[6], wr_data[7]};
          sw_fsel <= wr_data[3];
        end
        spread_en <= wr_data[1];
        sw_mode   <= wr_data[0];
      end
      if (wr_idx == 8'd1) oen <= wr_data[2];
    end
  end

  always_comb begin
    case (rd_idx)
      8'd0:    rd_data = ctl_byte(sw_mode, sw_code, sw_fsel, spread_en, pin_sel, pin_fsel);
      8'd1:    rd_data = {5'b0, oen, 2'b0};
      8'd6:    rd_data = {REV_ID, VENDOR_ID};
      default: rd_data = 8'h00;
    endcase
  end

  assign spread_code = sw_mode ? sw_code : {pin_sel, 1'b0};
  assign freq_sel    = sw_mode ? sw_fsel : pin_fsel;
  assign spread_on   = spread_en;
  assign out_en      = oen;

  // R9
  reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx > 8'd1) |=> $stable({sw_mode, sw_code, sw_fsel, spread_en, oen}));

  // R6
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 8'd0 && !sw_mode) |=> $stable({sw_code, sw_fsel}));

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'b1101010,
  parameter logic [3:0] REV_ID     = 4'h2,
  parameter logic [3:0] VENDOR_ID  = 4'h1,
  parameter int         SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_low,
  input  logic [2:0] pin_sel,
  input  logic       pin_fsel,
  output logic [3:0] spread_code,
  output logic       freq_sel,
  output logic       spread_on,
  output logic       out_en
);
  localparam int         BYTE_BITS = 8;
  localparam logic [2:0] LAST_BIT  = 3'(BYTE_BITS - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  smb_line_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_st_e    st, after;
  logic [2:0] bitcnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr, ptr, remain, rd_data;
  logic       ack_ok, sda_oe;

  // named events for the register bank and the assertions
  logic [7:0] byte_in;
  logic       rx_phase, byte_done, wr_fire;
  assign byte_in   = {rx_sr, sda_s};
  assign rx_phase  = (st == ST_ADDR) || (st == ST_IDX) || (st == ST_CNT) || (st == ST_WDATA);
  assign byte_done = rx_phase && scl_rise && (bitcnt == LAST_BIT);
  assign wr_fire   = byte_done && (st == ST_WDATA) && (remain != 8'd0);

  smb_cfg_regs #(.REV_ID(REV_ID), .VENDOR_ID(VENDOR_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_idx(ptr), .wr_data(byte_in),
    .rd_idx(ptr), .rd_data(rd_data), .pin_sel(pin_sel), .pin_fsel(pin_fsel),
    .spread_code(spread_code), .freq_sel(freq_sel), .spread_on(spread_on), .out_en(out_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      after  <= ST_IDLE;
      bitcnt <= 3'd0;
      rx_sr  <= 7'd0;
      tx_sr  <= 8'd0;
      ptr    <= 8'd0;
      remain <= 8'd0;
      ack_ok <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      st     <= ST_ADDR;
      bitcnt <= 3'd0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_IDX, ST_CNT, ST_WDATA: if (scl_rise) begin
          rx_sr  <= byte_in[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == LAST_BIT) begin
            st <= ST_ACK;
            case (st)
              ST_ADDR: begin
                if (byte_in[7:1] != DEV_ADDR) begin
                  ack_ok <= 1'b0;
                  after  <= ST_WAIT;
                end else if (byte_in[0]) begin
                  ack_ok <= 1'b1;
                  after  <= ST_TX;
                  tx_sr  <= count_for(ptr);
                end else begin
                  ack_ok <= 1'b1;
                  after  <= ST_IDX;
                end
              end
              ST_IDX: begin
                ptr    <= byte_in;
                ack_ok <= 1'b1;
                after  <= ST_CNT;
              end
              ST_CNT: begin
                remain <= byte_in;
                ack_ok <= 1'b1;
                after  <= ST_WDATA;
              end
              default: begin
                if (remain != 8'd0) begin
                  ptr    <= ptr + 8'd1;
                  remain <= remain - 8'd1;
                  ack_ok <= 1'b1;
                  after  <= ST_WDATA;
                end else begin
                  ack_ok <= 1'b0;
                  after  <= ST_WAIT;
                end
              end
            endcase
          end
        end
        ST_ACK: if (scl_fall) begin
          sda_oe <= ack_ok;
          st     <= ST_ACKHOLD;
        end
        ST_ACKHOLD: if (scl_fall) begin
          bitcnt <= 3'd0;
          st     <= after;
          sda_oe <= (after == ST_TX) ? ~tx_sr[7] : 1'b0;
        end
        ST_TX: begin
          if (scl_fall) begin
            tx_sr  <= {tx_sr[6:0], 1'b0};
            sda_oe <= ~tx_sr[6];
          end
          if (scl_rise) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == LAST_BIT) st <= ST_TXEND;
          end
        end
        ST_TXEND: if (scl_fall) begin
          sda_oe <= 1'b0;
          st     <= ST_HACK;
        end
        ST_HACK: if (scl_rise) begin
          if (!sda_s) begin
            tx_sr <= rd_data;
            ptr   <= ptr + 8'd1;
            st    <= ST_TXLOAD;
          end else begin
            st <= ST_WAIT;
          end
        end
        ST_TXLOAD: if (scl_fall) begin
          sda_oe <= ~tx_sr[7];
          bitcnt <= 3'd0;
          st     <= ST_TX;
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_low = sda_oe;

  // R10
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_ADDR) && !sda_pull_low);

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> (st == ST_IDLE) && !sda_pull_low);

  // R11
  drive_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_low |-> (st == ST_ACKHOLD || st == ST_TX || st == ST_TXEND));

  // R11
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> !scl_s);

  // R1
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sda_pull_low);

endmodule

// File: tb/tb_smb_cfg_slave.sv
`timescale 1ns/1ps
module tb_smb_cfg_slave;
  localparam int Q = 8;
  localparam logic [3:0] REV = 4'h2, VEN = 4'h1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_pull_low;
  logic [2:0] pin_sel = 3'b101;
  logic pin_fsel = 1'b1;
  logic [3:0] spread_code;
  logic freq_sel, spread_on, out_en;
  wire  sda_bus = sda_h & ~sda_pull_low;

  int errs = 0, checks = 0;

  // bench model of the register state
  logic m_sw = 1'b0, m_fsel = 1'b0, m_en = 1'b1, m_oen = 1'b1;
  logic [3:0] m_code = 4'h0;

  always #4 clk = ~clk;

  smb_cfg_slave #(.REV_ID(REV), .VENDOR_ID(VEN)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus), .sda_pull_low(sda_pull_low),
    .pin_sel(pin_sel), .pin_fsel(pin_fsel), .spread_code(spread_code), .freq_sel(freq_sel),
    .spread_on(spread_on), .out_en(out_en)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input logic [7:0] idx);
    if (idx == 8'd0)
      return m_sw ? {m_code[0], m_code[1], m_code[2], m_code[3], m_fsel, 1'b0, m_en, 1'b1}
                  : {1'b0, pin_sel[0], pin_sel[1], pin_sel[2], pin_fsel, 1'b0, m_en, 1'b0};
    if (idx == 8'd1) return m_oen ? 8'h04 : 8'h00;
    if (idx == 8'd6) return {REV, VEN};
    return 8'h00;
  endfunction

  function automatic string reg_req(input logic [7:0] idx);
    if (idx == 8'd0) return m_sw ? "R7" : "R6";
    if (idx == 8'd1) return "R8";
    return "R9";
  endfunction

  task automatic model_write(input logic [7:0] idx, input logic [7:0] d);
    if (idx == 8'd0) begin
      if (m_sw) begin
        m_code = {d[4], d[5], d[6], d[7]};
        m_fsel = d[3];
      end
      m_en = d[1];
      m_sw = d[0];
    end else if (idx == 8'd1) begin
      m_oen = d[2];
    end
  endtask

  task automatic check_outs(input string req);
    chk(req, "spread_code", 8'(spread_code), 8'(m_sw ? m_code : {pin_sel, 1'b0}));
    chk(req, "freq_sel", 8'(freq_sel), 8'(m_sw ? m_fsel : pin_fsel));
    chk(req, "spread_on", 8'(spread_on), 8'(m_en));
    chk(req, "out_en", 8'(out_en), 8'(m_oen));
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; qwait(); scl_h = 1'b1; qwait(); sda_h = 1'b0; qwait(); scl_h = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; qwait(); scl_h = 1'b1; qwait(); sda_h = 1'b1; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; qwait(); scl_h = 1'b1; qwait(); qwait(); scl_h = 1'b0; qwait();
    end
    sda_h = 1'b1; qwait(); scl_h = 1'b1; qwait();
    acked = (sda_bus == 1'b0);
    qwait(); scl_h = 1'b0; qwait();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      sda_h = 1'b1; qwait(); scl_h = 1'b1; qwait();
      b = {b[6:0], sda_bus};
      qwait(); scl_h = 1'b0; qwait();
    end
    sda_h = ack ? 1'b0 : 1'b1; qwait(); scl_h = 1'b1; qwait(); qwait(); scl_h = 1'b0; qwait();
  endtask

  // R2 / R3: indexed block write with up to two data bytes on the wire
  task automatic host_write(input logic [7:0] idx, input logic [7:0] cnt, input int nbytes,
                            input logic [7:0] d0, input logic [7:0] d1);
    logic a;
    bus_start();
    send_byte(8'hD4, a); chk("R1", "write address ack", 8'(a), 8'd1);
    send_byte(idx, a);   chk("R2", "index ack", 8'(a), 8'd1);
    send_byte(cnt, a);   chk("R2", "count ack", 8'(a), 8'd1);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] d = (i == 0) ? d0 : d1;
      send_byte(d, a);
      if (i < int'(cnt)) begin
        chk("R2", "data ack", 8'(a), 8'd1);
        model_write(idx + 8'(i), d);
      end else begin
        chk("R3", "surplus byte nack", 8'(a), 8'd0);
      end
    end
    bus_stop();
  endtask

  // R4: indexed block read
  task automatic host_read(input logic [7:0] idx, input int nbytes);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD4, a); chk("R1", "write address ack", 8'(a), 8'd1);
    send_byte(idx, a);   chk("R4", "read index ack", 8'(a), 8'd1);
    bus_start();
    send_byte(8'hD5, a); chk("R4", "read address ack", 8'(a), 8'd1);
    recv_byte(b, nbytes > 0);
    chk("R4", "count byte", b, (idx < 8'd7) ? 8'd7 - idx : 8'd0);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] j = idx + 8'(i);
      recv_byte(b, i != nbytes - 1);
      chk(reg_req(j), "register readback", b, exp_reg(j));
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // reset state: R5, R6, R8, R11
    chk("R11", "no pull after reset", 8'(sda_pull_low), 8'd0);
    chk("R5", "spread on at reset", 8'(spread_on), 8'd1);
    check_outs("R6");
    host_read(8'd0, 7);

    // hardware mode: bits 7:3 locked, bit1 still writable
    host_write(8'd0, 8'd1, 1, 8'hF8, 8'h00);
    check_outs("R6");
    host_read(8'd0, 1);
    pin_sel = 3'b010; pin_fsel = 1'b0;
    repeat (4) @(negedge clk);
    check_outs("R6");
    host_read(8'd0, 1);

    // output enable and reserved bits of register 1
    host_write(8'd1, 8'd1, 1, 8'hFB, 8'h00);
    check_outs("R8");
    host_read(8'd1, 1);

    // two-byte write across registers 0 and 1
    host_write(8'd0, 8'd2, 2, 8'h03, 8'hFF);
    check_outs("R2");
    host_read(8'd0, 2);

    // software mode sweep of all bits 7:3
    for (int v = 0; v < 32; v++) begin
      host_write(8'd0, 8'd1, 1, 8'((v << 3) | 3), 8'h00);
      check_outs("R7");
      host_read(8'd0, 1);
    end

    // surplus byte beyond count: would clear out_en if written
    host_write(8'd0, 8'd1, 2, 8'h53, 8'h00);
    check_outs("R3");

    // reserved and identity registers, read past the top
    host_write(8'd5, 8'd2, 2, 8'hFF, 8'hFF);
    check_outs("R9");
    host_read(8'd5, 3);
    host_read(8'd9, 1);

    // foreign address: NACK and silence until next START
    bus_start();
    send_byte(8'hA8, a); chk("R1", "foreign address nack", 8'(a), 8'd0);
    send_byte(8'h00, a); chk("R1", "silent after foreign", 8'(a), 8'd0);
    bus_stop();
    chk("R10", "released after stop", 8'(sda_pull_low), 8'd0);
    host_read(8'd0, 1);

    // back to hardware mode: pins take over, S0 forced to 0
    host_write(8'd0, 8'd1, 1, 8'h02, 8'h00);
    check_outs("R6");
    host_read(8'd0, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule